// File: doc/BRIEF.md
# SMRAM access control decoder

This block holds the two configuration dwords that govern the legacy system-management memory window and the legacy memory hole below 16 MB. It also decides, for every memory access presented to it, whether the access goes to DRAM or is forwarded to the downstream bus. Software programs the controls through a dword configuration port. Reads return the live register contents, and bits that are not implemented read as zero.

The decode port takes an address, a flag that says the access is made in system-management mode, a flag that says it is an instruction fetch rather than a data reference, and a valid strobe. The route decision is registered and appears on the clock edge that samples the strobe. A set-only lock bit lets initialisation code open the window for setup and then freeze it until the next reset.

Top module: `smram_access_ctl`

## Requirements
- R1: After reset the control fields (open, closed, lock, global enable, hole enable) are 0. A read of offset 4Ch returns 0x00000200 and a read of offset 48h returns 0. `lock_state`, `dec_done`, `dec_to_dram` and `conflict_seen` are 0.
- R2: Lock is bit 12 of offset 4Ch. Writing 1 sets it. Writing 0 has no effect. Only reset clears it. `lock_state` shows its value.
- R3: A write to offset 4Ch that sets lock while the block is unlocked leaves open (bit 14) at 0, whatever the write carried in bit 14.
- R4: While lock is 1, writes to open (bit 14) and global enable (bit 11) are ignored. Closed (bit 13) and hole enable (bit 7 of offset 48h) stay writable.
- R5: Bits 10:8 of offset 4Ch always read 3'b010 and cannot be written. Every other bit outside the named fields reads 0. Reads of any offset other than 48h and 4Ch return 0.
- R6: For an access in the window 0xA0000–0xBFFFF in system-management mode, the route is DRAM when (global enable is 1, or open is 1 with lock 0) and (the access is a code fetch, or closed is 0). Otherwise the access is forwarded.
- R7: For an access in the window outside system-management mode, the route is DRAM only when open is 1 and lock is 0. Otherwise the access is forwarded.
- R8: When hole enable is 1, addresses 0xF00000 through 0xFFFFFF are forwarded. Every other address outside the window is routed to DRAM, and so is the hole range when hole enable is 0.
- R9: `dec_done` and `dec_to_dram` (1 = DRAM, 0 = forward) change on the clock edge that samples `dec_valid` high. `dec_done` is high only for the cycle after a valid access, and `dec_to_dram` holds its value while `dec_valid` is low.
- R10: `conflict_seen` becomes 1 one cycle after open and closed are both 1. It stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration byte offset (dword aligned) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| dec_valid | input | 1 | Access strobe |
| dec_addr | input | ADDR_W | Access address |
| dec_smm | input | 1 | Access made in system-management mode |
| dec_code | input | 1 | 1 = code fetch, 0 = data reference |
| dec_done | output | 1 | Registered: a decision was taken last cycle |
| dec_to_dram | output | 1 | Registered route: 1 = DRAM, 0 = forward |
| lock_state | output | 1 | Current lock bit |
| conflict_seen | output | 1 | Sticky flag: open and closed were set together |

## Verification
The hardest state to reach is the locked state combined with each starting mix of global enable, closed and hole enable. Lock is only ever cleared by reset, so a single run cannot walk through those states in order. The bench therefore resets before each of the sixteen control mixes and sets lock on the same write that loads the mix. It then writes the bitwise complement to show which fields stay frozen. Finally it sweeps every window, hole and boundary address under all four mode and reference combinations. Setting open and closed together is also part of the unlocked sweep, so the priority between the two and the sticky conflict flag are both exercised.

// File: rtl/smram_pkg.sv
package smram_pkg;

    // Configuration offsets (byte addresses, dword aligned)
    localparam logic [7:0] OFS_HOLE = 8'h48;
    localparam logic [7:0] OFS_SMM  = 8'h4C;

    // Bit positions inside the two dwords
    localparam int HOLE_BIT = 7;
    localparam int OPEN_BIT = 14;
    localparam int SHUT_BIT = 13;
    localparam int LOCK_BIT = 12;
    localparam int GLOB_BIT = 11;
    localparam int SEG_LSB  = 8;

    localparam logic [2:0] SEG_FIXED = 3'b010;

    // Address ranges (inclusive bounds)
    localparam logic [31:0] WIN_LO  = 32'h000A_0000;
    localparam logic [31:0] WIN_HI  = 32'h000B_FFFF;
    localparam logic [31:0] HOLE_LO = 32'h00F0_0000;
    localparam logic [31:0] HOLE_HI = 32'h00FF_FFFF;

    typedef struct packed {
        logic open;
        logic shut;
        logic lock;
        logic glob;
    } smm_ctl_t;

    typedef enum logic {
        ROUTE_FWD  = 1'b0,
        ROUTE_DRAM = 1'b1
    } route_e;

    function automatic logic [31:0] smm_word(input smm_ctl_t c);
        logic [31:0] w;
        w = '0;
        w[OPEN_BIT] = c.open;
        w[SHUT_BIT] = c.shut;
        w[LOCK_BIT] = c.lock;
        w[GLOB_BIT] = c.glob;
        w[SEG_LSB +: 3] = SEG_FIXED;
        return w;
    endfunction

    function automatic logic [31:0] hole_word(input logic en);
        logic [31:0] w;
        w = '0;
        w[HOLE_BIT] = en;
        return w;
    endfunction

    // Window grant, before the address check
    function automatic route_e window_route(input smm_ctl_t c, input logic smm,
                                            input logic code);
        logic ovr;
        logic ok;
        ovr = c.open & ~c.lock;
        if (smm)
            ok = (c.glob | ovr) & (code | ~c.shut);
        else
            ok = ovr;
        return ok ? ROUTE_DRAM : ROUTE_FWD;
    endfunction

endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
    import smram_pkg::*;
#(
    parameter int CFG_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CFG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output smm_ctl_t          ctl,
    output logic              hole_on,
    output logic              conflict
);

    localparam logic [CFG_AW-1:0] SMM_OFS  = CFG_AW'(OFS_SMM);
    localparam logic [CFG_AW-1:0] HOLE_OFS = CFG_AW'(OFS_HOLE);

    smm_ctl_t ctl_q;
    logic     hole_q;
    logic     conf_q;

    logic hit_smm;
    logic hit_hole;

    assign hit_smm  = (addr[CFG_AW-1:2] == SMM_OFS[CFG_AW-1:2]);
    assign hit_hole = (addr[CFG_AW-1:2] == HOLE_OFS[CFG_AW-1:2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            hole_q <= 1'b0;
            conf_q <= 1'b0;
        end else begin
            if (wr && hit_smm) begin
                ctl_q.shut <= wdata[SHUT_BIT];
                if (!ctl_q.lock) begin
                    ctl_q.glob <= wdata[GLOB_BIT];
                    ctl_q.open <= wdata[OPEN_BIT] & ~wdata[LOCK_BIT];
                    ctl_q.lock <= wdata[LOCK_BIT];
                end
            end
            if (wr && hit_hole)
                hole_q <= wdata[HOLE_BIT];
            conf_q <= conf_q | (ctl_q.open & ctl_q.shut);
        end
    end

    always_comb begin
        if (hit_smm)
            rdata = smm_word(ctl_q);
        else if (hit_hole)
            rdata = hole_word(hole_q);
        else
            rdata = '0;
    end

    logic unused_bits;
    assign unused_bits = ^{addr[1:0], wdata[31:15], wdata[10:8], wdata[6:0]};

    assign ctl      = ctl_q;
    assign hole_on  = hole_q;
    assign conflict = conf_q;

    // R2
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.lock |=> ctl_q.lock);

    // R3
    lock_clears_open_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && hit_smm && wdata[LOCK_BIT]) |=> !ctl_q.open);

    // R4
    locked_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.lock |=> ($stable(ctl_q.open) && $stable(ctl_q.glob)));

    // R10
    conflict_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        conf_q |=> conf_q);

endmodule

// File: rtl/smram_window_decode.sv
module smram_window_decode
    import smram_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              smm,
    input  logic              code,
    input  smm_ctl_t          ctl,
    input  logic              hole_on,
    output route_e            route
);

    localparam logic [ADDR_W-1:0] W_LO = ADDR_W'(WIN_LO);
    localparam logic [ADDR_W-1:0] W_HI = ADDR_W'(WIN_HI);
    localparam logic [ADDR_W-1:0] H_LO = ADDR_W'(HOLE_LO);
    localparam logic [ADDR_W-1:0] H_HI = ADDR_W'(HOLE_HI);

    logic in_win;
    logic in_hole;

    assign in_win  = (addr >= W_LO) && (addr <= W_HI);
    assign in_hole = (addr >= H_LO) && (addr <= H_HI);

    always_comb begin
        if (in_win)
            route = window_route(ctl, smm, code);
        else if (in_hole && hole_on)
            route = ROUTE_FWD;
        else
            route = ROUTE_DRAM;
    end

endmodule

// File: rtl/smram_access_ctl.sv
module smram_access_ctl
    import smram_pkg::*;
#(
    parameter int CFG_AW = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              dec_valid,
    input  logic [ADDR_W-1:0] dec_addr,
    input  logic              dec_smm,
    input  logic              dec_code,
    output logic              dec_done,
    output logic              dec_to_dram,
    output logic              lock_state,
    output logic              conflict_seen
);

    localparam logic [ADDR_W-1:0] A_WLO = ADDR_W'(WIN_LO);
    localparam logic [ADDR_W-1:0] A_WHI = ADDR_W'(WIN_HI);
    localparam logic [ADDR_W-1:0] A_HLO = ADDR_W'(HOLE_LO);
    localparam logic [ADDR_W-1:0] A_HHI = ADDR_W'(HOLE_HI);

    smm_ctl_t ctl;
    logic     hole_on;
    route_e   route_d;
    route_e   route_q;
    logic     done_q;

    smram_cfg_regs #(.CFG_AW(CFG_AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_wr),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .ctl      (ctl),
        .hole_on  (hole_on),
        .conflict (conflict_seen)
    );

    smram_window_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (dec_addr),
        .smm     (dec_smm),
        .code    (dec_code),
        .ctl     (ctl),
        .hole_on (hole_on),
        .route   (route_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= ROUTE_FWD;
            done_q  <= 1'b0;
        end else begin
            done_q <= dec_valid;
            if (dec_valid)
                route_q <= route_d;
        end
    end

    assign dec_done    = done_q;
    assign dec_to_dram = (route_q == ROUTE_DRAM);
    assign lock_state  = ctl.lock;

    logic a_win;
    logic a_hole;
    assign a_win  = (dec_addr >= A_WLO) && (dec_addr <= A_WHI);
    assign a_hole = (dec_addr >= A_HLO) && (dec_addr <= A_HHI);

    // R9
    done_follow_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> dec_done);

    // R9
    route_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> ($stable(dec_to_dram) && !dec_done));

    // R8
    hole_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && hole_on && a_hole) |=> !dec_to_dram);

    // R7
    nonsmm_shut_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_smm && a_win && !ctl.open) |=> !dec_to_dram);

    // R6
    smm_data_block_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_smm && !dec_code && ctl.shut && a_win) |=> !dec_to_dram);

endmodule

// File: tb/sim_smram_access_ctl.sv
module sim_smram_access_ctl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        dec_valid = 1'b0;
    logic [31:0] dec_addr = '0;
    logic        dec_smm = 1'b0;
    logic        dec_code = 1'b0;
    logic        dec_done;
    logic        dec_to_dram;
    logic        lock_state;
    logic        conflict_seen;

    int checks = 0;
    int errors = 0;

    // bench model of the control state
    logic m_open, m_shut, m_lock, m_glob, m_hole, m_conf;

    always #10 clk = ~clk;

    smram_access_ctl u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dec_valid(dec_valid),
        .dec_addr(dec_addr), .dec_smm(dec_smm), .dec_code(dec_code),
        .dec_done(dec_done), .dec_to_dram(dec_to_dram), .lock_state(lock_state),
        .conflict_seen(conflict_seen)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        {m_open, m_shut, m_lock, m_glob, m_hole, m_conf} = '0;
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (a == 8'h4C) begin
            m_shut = d[13];
            if (!m_lock) begin
                m_glob = d[11];
                m_open = d[14] & ~d[12];
                m_lock = d[12];
            end
        end else if (a == 8'h48) begin
            m_hole = d[7];
        end
        m_conf = m_conf | (m_open & m_shut);
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
        cfg_addr = a;
        #2;
        d = cfg_rdata;
    endtask

    function automatic logic [31:0] exp_smm_word();
        return (32'(m_open) << 14) | (32'(m_shut) << 13) | (32'(m_lock) << 12)
             | (32'(m_glob) << 11) | 32'h200;
    endfunction

    function automatic logic exp_route(input logic [31:0] a, input logic s, input logic c);
        logic ovr;
        ovr = m_open & ~m_lock;
        if (a >= 32'hA0000 && a <= 32'hBFFFF)
            return s ? ((m_glob | ovr) & (c | ~m_shut)) : ovr;
        if (m_hole && a >= 32'hF00000 && a < 32'h1000000)
            return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [31:0] addr_at(input int i);
        case (i)
            0: return 32'h0009_FFFF;
            1: return 32'h000A_0000;
            2: return 32'h000B_0123;
            3: return 32'h000B_FFFF;
            4: return 32'h000C_0000;
            5: return 32'h00EF_FFFF;
            6: return 32'h00F0_0000;
            7: return 32'h00FF_FFFF;
            default: return 32'h0100_0000;
        endcase
    endfunction

    task automatic run_dec(input logic [31:0] a, input logic s, input logic c);
        logic e;
        e = exp_route(a, s, c);
        @(negedge clk);
        dec_valid = 1'b1; dec_addr = a; dec_smm = s; dec_code = c;
        @(negedge clk);
        dec_valid = 1'b0;
        chk("R9 done", 32'(dec_done), 32'd1);
        if (a >= 32'hA0000 && a <= 32'hBFFFF)
            chk(s ? "R6 window smm route" : "R7 window non-smm route",
                32'(dec_to_dram), 32'(e));
        else
            chk("R8 outside-window route", 32'(dec_to_dram), 32'(e));
    endtask

    task automatic sweep_dec();
        for (int i = 0; i < 9; i++)
            for (int m = 0; m < 4; m++)
                run_dec(addr_at(i), m[1], m[0]);
    endtask

    initial begin
        logic [31:0] rd;
        logic        held;
        do_reset();

        // R1 reset state
        cfg_read(8'h4C, rd); chk("R1 reset 4Ch", rd, 32'h0000_0200);
        cfg_read(8'h48, rd); chk("R1 reset 48h", rd, 32'h0);
        chk("R1 reset lock", 32'(lock_state), 32'd0);
        chk("R1 reset done", 32'(dec_done), 32'd0);
        chk("R1 reset route", 32'(dec_to_dram), 32'd0);
        chk("R1 reset conflict", 32'(conflict_seen), 32'd0);

        // R5 read-only segment, zero bits, other offsets
        cfg_write(8'h4C, 32'hFFFF_87FF & ~32'h0000_1000 & ~32'h0000_6800);
        cfg_read(8'h4C, rd); chk("R5 segment fixed", rd, exp_smm_word());
        cfg_write(8'h48, 32'hFFFF_FF7F);
        cfg_read(8'h48, rd); chk("R5 hole dword zero bits", rd, 32'h0);
        cfg_read(8'h44, rd); chk("R5 other offset", rd, 32'h0);
        cfg_read(8'h50, rd); chk("R5 other offset", rd, 32'h0);

        // unlocked sweep over open, closed, global enable, hole enable
        for (int k = 0; k < 16; k++) begin
            cfg_write(8'h48, 32'(k[3]) << 7);
            cfg_write(8'h4C, (32'(k[0]) << 14) | (32'(k[1]) << 13) | (32'(k[2]) << 11));
            cfg_read(8'h4C, rd); chk("R5 readback 4Ch", rd, exp_smm_word());
            cfg_read(8'h48, rd); chk("R8 readback 48h", rd, 32'(m_hole) << 7);
            sweep_dec();
            chk("R10 conflict flag", 32'(conflict_seen), 32'(m_conf));
        end

        // R9 hold while valid stays low
        held = dec_to_dram;
        repeat (3) @(negedge clk);
        chk("R9 hold", 32'(dec_to_dram), 32'(held));
        chk("R9 done low", 32'(dec_done), 32'd0);

        // locked sweep: reset before each mix, lock on the loading write
        for (int k = 0; k < 16; k++) begin
            do_reset();
            chk("R2 reset clears lock", 32'(lock_state), 32'd0);
            cfg_write(8'h48, 32'(k[3]) << 7);
            cfg_write(8'h4C, 32'h4000 | 32'h1000 | (32'(k[1]) << 13) | (32'(k[2]) << 11));
            cfg_read(8'h4C, rd); chk("R3 lock write clears open", rd, exp_smm_word());
            chk("R2 lock set", 32'(lock_state), 32'd1);
            // complement: try to reopen, flip enable, flip closed, write lock 0
            cfg_write(8'h4C, 32'h4000 | (32'(~k[1]) << 13) | (32'(~k[2]) << 11));
            cfg_write(8'h48, 32'(~k[3]) << 7);
            cfg_read(8'h4C, rd); chk("R4 locked fields frozen", rd, exp_smm_word());
            cfg_read(8'h48, rd); chk("R4 hole writable when locked", rd, 32'(m_hole) << 7);
            chk("R2 write zero keeps lock", 32'(lock_state), 32'd1);
            sweep_dec();
            chk("R10 conflict flag locked", 32'(conflict_seen), 32'(m_conf));
        end

        // R10 sticky: set open+closed, then clear both
        do_reset();
        cfg_write(8'h4C, 32'h6000);
        cfg_write(8'h4C, 32'h0000);
        @(negedge clk);
        chk("R10 sticky after clear", 32'(conflict_seen), 32'd1);
        // R6 priority with both set: smm data blocked, non-smm granted
        cfg_write(8'h4C, 32'h6800);
        run_dec(32'hA8000, 1'b1, 1'b0);
        run_dec(32'hA8000, 1'b0, 1'b0);
        run_dec(32'hA8000, 1'b1, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog act=timeout exp=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule